// File: doc/BRIEF.md
# Semi-Transparent Pixel Blend Unit

This block sits at the write end of a pixel pipeline. It takes a 16-bit foreground pixel and the 16-bit pixel already stored at the target location. It produces the pixel to store, plus a write enable that says whether the store may go ahead. A pixel holds three 5-bit colour channels and a mask bit. Red is in bits 4:0, green in bits 9:5, blue in bits 14:10 and the mask bit in bit 15.

When blending is enabled, a 2-bit mode selects one of four per-channel equations, each with saturating arithmetic. When blending is off, the foreground colour passes through unchanged. Independently, two mask controls apply:

- The protect control vetoes the write when the stored pixel's mask bit is set.
- The stamp control forces the mask bit of the written pixel to one.

The result is registered once, so every output lags its inputs by exactly one clock.

Top module: `px_blend_unit`

## Requirements
- R1: While reset is high and on the first clock after it, out_valid is 0, out_we is 0 and out_px is 0.
- R2: out_valid equals in_valid of the previous clock.
- R3: With blend_en=1 and blend_mode=0, each output channel is floor((background + foreground) / 2).
- R4: With blend_en=1 and blend_mode=1, each output channel is background + foreground, limited to 31.
- R5: With blend_en=1 and blend_mode=2, each output channel is background - foreground, limited below at 0.
- R6: With blend_en=1 and blend_mode=3, each output channel is background + floor(foreground / 4), limited to 31.
- R7: With blend_en=0, output bits 14:0 equal foreground bits 14:0 whatever blend_mode and the background hold.
- R8: When mask_chk=1 and background bit 15 is 1, out_we is 0. For any other accepted pixel, out_we is 1.
- R9: Output bit 15 is foreground bit 15 ORed with mask_set. This holds both with blending on and with blending off.
- R10: out_we is never 1 while out_valid is 0.
- R11: On a clock where in_valid is 0, out_px keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel pair is valid |
| fg_px | input | 16 | Foreground (source) pixel |
| bg_px | input | 16 | Background (stored) pixel |
| blend_en | input | 1 | 1 = apply the blend equation, 0 = pass the foreground through |
| blend_mode | input | 2 | 0 = average, 1 = add, 2 = subtract, 3 = add a quarter |
| mask_chk | input | 1 | Protect stored pixels whose mask bit is set |
| mask_set | input | 1 | Force the mask bit of the written pixel |
| out_valid | output | 1 | Result is valid |
| out_px | output | 16 | Resulting pixel |
| out_we | output | 1 | Write permitted |

## Verification
Two things can act on the same pixel in one cycle: the colour arithmetic, including its clamping, and the mask gate. They are independent, so a veto must not disturb the computed colour, and a saturating result must not disturb the veto. The bench drives a pixel whose background has bit 15 set while protect is on and the add mode saturates. It also drives stamp and protect together, so that the result carries a forced mask bit while its write is withheld. A behavioural model judges each cycle on colour, mask bit and write enable together.

// File: rtl/px_blend_pkg.sv
package px_blend_pkg;
  parameter int DEF_CH_W   = 5;
  parameter int DEF_NUM_CH = 3;

  typedef enum logic [1:0] {
    BLEND_AVG = 2'd0,
    BLEND_ADD = 2'd1,
    BLEND_SUB = 2'd2,
    BLEND_QTR = 2'd3
  } blend_mode_e;
endpackage

// File: rtl/px_blend_chan.sv
module px_blend_chan
  import px_blend_pkg::*;
#(
  parameter int CH_W = DEF_CH_W
) (
  input  logic [CH_W-1:0] fg_c,
  input  logic [CH_W-1:0] bg_c,
  input  blend_mode_e     mode,
  input  logic            en,
  output logic [CH_W-1:0] res_c
);
  localparam logic [CH_W-1:0] CH_MAX = {CH_W{1'b1}};

  logic [CH_W:0]   sum_full;
  logic [CH_W:0]   sum_qtr;
  logic [CH_W-1:0] mix;

  assign sum_full = {1'b0, bg_c} + {1'b0, fg_c};
  assign sum_qtr  = {1'b0, bg_c} + {3'b000, fg_c[CH_W-1:2]};

  always_comb begin
    unique case (mode)
      BLEND_AVG: mix = sum_full[CH_W:1];
      BLEND_ADD: mix = sum_full[CH_W] ? CH_MAX : sum_full[CH_W-1:0];
      BLEND_SUB: mix = (bg_c < fg_c) ? '0 : (bg_c - fg_c);
      BLEND_QTR: mix = sum_qtr[CH_W] ? CH_MAX : sum_qtr[CH_W-1:0];
      default:   mix = fg_c;
    endcase
  end

  assign res_c = en ? mix : fg_c;
endmodule

// File: rtl/px_mask_gate.sv
module px_mask_gate (
  input  logic valid,
  input  logic fg_msk,
  input  logic bg_msk,
  input  logic chk,
  input  logic set,
  output logic we,
  output logic msk_out
);
  assign we      = valid & ~(chk & bg_msk);
  assign msk_out = fg_msk | set;
endmodule

// File: rtl/px_blend_unit.sv
module px_blend_unit
  import px_blend_pkg::*;
#(
  parameter int CH_W   = DEF_CH_W,
  parameter int NUM_CH = DEF_NUM_CH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [CH_W*NUM_CH:0]   fg_px,
  input  logic [CH_W*NUM_CH:0]   bg_px,
  input  logic                   blend_en,
  input  logic [1:0]             blend_mode,
  input  logic                   mask_chk,
  input  logic                   mask_set,
  output logic                   out_valid,
  output logic [CH_W*NUM_CH:0]   out_px,
  output logic                   out_we
);
  localparam int RGB_W = CH_W * NUM_CH;
  localparam int MSB   = RGB_W;

  blend_mode_e      mode_q;
  logic [RGB_W-1:0] rgb_mix;
  logic             we_d;
  logic             msk_d;

  assign mode_q = blend_mode_e'(blend_mode);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_chan
    px_blend_chan #(.CH_W(CH_W)) u_chan (
      .fg_c  (fg_px[gi*CH_W +: CH_W]),
      .bg_c  (bg_px[gi*CH_W +: CH_W]),
      .mode  (mode_q),
      .en    (blend_en),
      .res_c (rgb_mix[gi*CH_W +: CH_W])
    );
  end

  px_mask_gate u_gate (
    .valid   (in_valid),
    .fg_msk  (fg_px[MSB]),
    .bg_msk  (bg_px[MSB]),
    .chk     (mask_chk),
    .set     (mask_set),
    .we      (we_d),
    .msk_out (msk_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
      out_px    <= '0;
    end else begin
      out_valid <= in_valid;
      out_we    <= we_d;
      if (in_valid) out_px <= {msk_d, rgb_mix};
    end
  end
endmodule

// File: rtl/px_blend_chk.sv
module px_blend_chk
  import px_blend_pkg::*;
#(
  parameter int CH_W   = DEF_CH_W,
  parameter int NUM_CH = DEF_NUM_CH
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [CH_W*NUM_CH:0] fg_px,
  input logic [CH_W*NUM_CH:0] bg_px,
  input logic                 blend_en,
  input logic [1:0]           blend_mode,
  input logic                 mask_chk,
  input logic                 mask_set,
  input logic                 out_valid,
  input logic [CH_W*NUM_CH:0] out_px,
  input logic                 out_we
);
  localparam int MSB = CH_W * NUM_CH;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_we && out_px == '0));

  p_valid_lag_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_lag_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_sub_floor_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && blend_en && blend_mode == 2'd2) |=>
      out_px[CH_W-1:0] <= $past(bg_px[CH_W-1:0]));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !blend_en) |=> out_px[MSB-1:0] == $past(fg_px[MSB-1:0]));

  p_veto_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_chk && bg_px[MSB]) |=> !out_we);

  p_open_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(mask_chk && bg_px[MSB])) |=> out_we);

  p_stamp_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_set) |=> out_px[MSB]);

  p_we_gate_r10: assert property (@(posedge clk) disable iff (rst)
    out_we |-> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_px));
endmodule

bind px_blend_unit px_blend_chk u_px_blend_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .fg_px      (fg_px),
  .bg_px      (bg_px),
  .blend_en   (blend_en),
  .blend_mode (blend_mode),
  .mask_chk   (mask_chk),
  .mask_set   (mask_set),
  .out_valid  (out_valid),
  .out_px     (out_px),
  .out_we     (out_we)
);

// File: tb/test_px_blend_unit.sv
module test_px_blend_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] fg_px = '0;
  logic [15:0] bg_px = '0;
  logic        blend_en = 1'b0;
  logic [1:0]  blend_mode = '0;
  logic        mask_chk = 1'b0;
  logic        mask_set = 1'b0;
  logic        out_valid;
  logic [15:0] out_px;
  logic        out_we;

  int          n_checks = 0;
  int          n_errors = 0;
  int          cycles   = 0;
  logic [15:0] exp_px   = '0;
  logic [31:0] lfsr     = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  px_blend_unit i_px_blend_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fg_px(fg_px), .bg_px(bg_px),
    .blend_en(blend_en), .blend_mode(blend_mode), .mask_chk(mask_chk),
    .mask_set(mask_set), .out_valid(out_valid), .out_px(out_px), .out_we(out_we)
  );

  function automatic int ref_chan(int b, int f, int m, bit en);
    int r;
    if (!en) return f;
    case (m)
      0: r = (b + f) / 2;
      1: r = b + f;
      2: r = b - f;
      default: r = b + f / 4;
    endcase
    if (r > 31) r = 31;
    if (r < 0) r = 0;
    return r;
  endfunction

  task automatic check(string tag, logic [15:0] apx, logic [15:0] epx,
                       logic av, logic ev, logic aw, logic ew);
    n_checks++;
    if (apx !== epx || av !== ev || aw !== ew) begin
      n_errors++;
      $display("FAIL %s: actual px=%h valid=%b we=%b expected px=%h valid=%b we=%b",
               tag, apx, av, aw, epx, ev, ew);
    end
  endtask

  task automatic step(string tag, bit v, logic [15:0] f, logic [15:0] b,
                      bit en, int m, bit chk, bit set);
    logic ew;
    @(negedge clk);
    in_valid = v; fg_px = f; bg_px = b; blend_en = en;
    blend_mode = 2'(m); mask_chk = chk; mask_set = set;
    ew = v && !(chk && b[15]);
    if (v) begin
      exp_px[15] = f[15] | set;
      for (int c = 0; c < 3; c++)
        exp_px[c*5 +: 5] = 5'(ref_chan(int'(b[c*5 +: 5]), int'(f[c*5 +: 5]), m, en));
    end
    @(posedge clk);
    #1;
    check(tag, out_px, exp_px, out_valid, v, out_we, ew);
  endtask

  function automatic logic [15:0] px(int r, int g, int bl, bit mk);
    return {mk, 5'(bl), 5'(g), 5'(r)};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual run still going expected finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", out_px, 16'h0000, out_valid, 1'b0, out_we, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // R3 average: floor of sum halves
    step("R3 avg", 1, px(31, 1, 0, 0), px(31, 0, 7, 0), 1, 0, 0, 0);
    // R4 add with saturation on red, plain add on green
    step("R4 add", 1, px(20, 3, 31, 0), px(20, 4, 1, 0), 1, 1, 0, 0);
    // R5 subtract clamps at zero
    step("R5 sub", 1, px(9, 2, 31, 0), px(5, 10, 31, 0), 1, 2, 0, 0);
    // R6 quarter add: 10+7=17, 28+7 saturates, 3+0
    step("R6 qtr", 1, px(31, 31, 3, 0), px(10, 28, 3, 0), 1, 3, 0, 0);
    // R7 blend disabled: mode ignored, foreground passes
    step("R7 pass", 1, px(4, 17, 30, 0), px(31, 31, 31, 1), 0, 2, 0, 0);
    // R9 stamp with blend off and with blend on
    step("R9 stamp off", 1, px(1, 2, 3, 0), px(0, 0, 0, 0), 0, 0, 0, 1);
    step("R9 stamp on", 1, px(1, 2, 3, 1), px(8, 8, 8, 0), 1, 1, 0, 0);
    // R8 veto coinciding with saturating add, and with stamp
    step("R8 veto+sat", 1, px(25, 25, 25, 0), px(25, 25, 25, 1), 1, 1, 1, 0);
    step("R8 veto+stamp", 1, px(2, 2, 2, 0), px(6, 6, 6, 1), 1, 2, 1, 1);
    step("R8 chk clear", 1, px(2, 2, 2, 0), px(6, 6, 6, 0), 1, 2, 1, 0);
    step("R8 no chk", 1, px(2, 2, 2, 0), px(6, 6, 6, 1), 1, 0, 0, 0);
    // R10 / R11 / R2 idle cycles hold pixel, no write
    step("R11 idle hold", 0, 16'hFFFF, 16'hFFFF, 1, 1, 0, 1);
    step("R10 idle no we", 0, 16'h1234, 16'h0000, 0, 0, 0, 0);
    step("R2 resume", 1, px(16, 0, 31, 0), px(15, 31, 0, 0), 1, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2 R3 R4 R5 R6 R8 R9 mix", lfsr[31] | lfsr[30], lfsr[15:0],
           lfsr[29:14], lfsr[2], int'(lfsr[5:4]), lfsr[7], lfsr[9]);
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule